// File: doc/BRIEF.md
# RC Time-Constant Calibration Controller

This block keeps a 3-bit resistor-bank code matched to the real RC product of the die. When asked to calibrate, it times one high phase of an on-chip RC reference oscillator against the system clock. The system clock runs 64 times faster than the nominal oscillator, so a nominal high phase lasts 32 clocks. From that measurement it computes a corrected code in a single pass.

A down-counter is loaded with 32 and decrements on every clock while the synchronized oscillator is high. The signed value left in it tells how far the RC product has drifted. That value is halved with rounding and added to the present code. The result is clamped to the code range. It is then written once and held until the next request. A measurement that never ends is abandoned after a bounded number of cycles, and the code is left as it was.

Top module: `rc_tune_ctrl`

## Requirements
- R1: After reset the code output is 4, and the done, busy, saturation and timeout outputs are all 0.
- R2: A start request while idle raises busy on the next clock. A start request while busy has no effect on the measurement or its result.
- R3: Exactly one high phase is measured: the first synchronized rising edge after the start is the beginning, and the next falling edge is the end. A high phase already in progress when start arrives is not measured.
- R4: With H the number of clocks the oscillator input is high, the residue is 32 - H. The residue is halved with ties rounded away from zero (1 gives 1, 2 gives 1, 3 gives 2, -1 gives -1, -3 gives -2). The new code is the old code plus that halved value.
- R5: A high phase of exactly 32 clocks leaves the code unchanged. A longer phase lowers the code and a shorter phase raises it.
- R6: A corrected code below 0 is written as 0 and one above 7 as 7. In either case the saturation output is 1 after that update.
- R7: Done is high for exactly one clock, in the same cycle the new code first appears. The code does not change in any other cycle.
- R8: If a measurement has not ended 128 clocks after it began, it is abandoned. The timeout output goes to 1, busy returns to 0, done stays 0 and the code is unchanged.
- R9: An accepted start clears the saturation and timeout outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 64 times the nominal oscillator frequency |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration request, sampled each clock |
| osc_i | input | 1 | Raw reference oscillator output, asynchronous |
| code_o | output | 3 | Resistor bank code, 0 is the smallest resistance |
| busy_o | output | 1 | A measurement is in progress |
| done_o | output | 1 | One-clock pulse when a new code is written |
| sat_o | output | 1 | The last correction was clamped at 0 or 7 |
| timeout_o | output | 1 | The last measurement was abandoned |

## Verification
The assertions assume that start is a clean synchronous level and that the oscillator input, although asynchronous, holds each level for several clocks. That is what the 50% duty cycle and the 64:1 frequency ratio imply. The stimulus changes the oscillator input only on falling clock edges and holds each high phase for a whole number of clocks. The measured length is therefore exactly known, and the expected code follows from the rounding rule with no uncertainty from the synchronizer. Long phases are kept well inside the 128-clock abort window, except in the one test that holds the input low on purpose to reach that limit.

// File: rtl/rc_tune_pkg.sv
package rc_tune_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_MEAS  = 2'd2,
    ST_WRITE = 2'd3
  } tune_state_t;

  typedef struct packed {
    logic [7:0] code;
    logic       clamped;
  } upd_result_t;

  // halve a signed residue, ties away from zero
  function automatic int halve_round(input int r);
    int mag;
    mag = (r < 0) ? -r : r;
    mag = (mag + 1) >>> 1;
    return (r < 0) ? -mag : mag;
  endfunction

  // add correction to code and clamp into 0..max_code
  function automatic upd_result_t clamp_add(input int code, input int adj, input int max_code);
    upd_result_t res;
    int sum;
    sum = code + adj;
    res.clamped = 1'b0;
    if (sum < 0) begin
      sum = 0;
      res.clamped = 1'b1;
    end else if (sum > max_code) begin
      sum = max_code;
      res.clamped = 1'b1;
    end
    res.code = 8'(sum);
    return res;
  endfunction

endpackage

// File: rtl/rc_osc_sync.sv
module rc_osc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_raw,
  output logic osc_hi,
  output logic osc_rise,
  output logic osc_fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= osc_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign osc_hi   = chain[STAGES-1];
  assign osc_rise = chain[STAGES-1] & ~last_q;
  assign osc_fall = ~chain[STAGES-1] & last_q;
endmodule

// File: rtl/rc_phase_counter.sv
module rc_phase_counter #(
  parameter int PRESET  = 32,
  parameter int TIMEOUT = 128,
  localparam int CNT_W  = $clog2(PRESET + TIMEOUT) + 1,
  localparam int TMR_W  = $clog2(TIMEOUT) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    dec,
  input  logic                    run,
  output logic signed [CNT_W-1:0] residue,
  output logic                    expired
);
  logic signed [CNT_W-1:0] cnt_q;
  logic        [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= CNT_W'(PRESET);
    else if (load) cnt_q <= CNT_W'(PRESET);
    else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tmr_q <= '0;
    else if (load)              tmr_q <= '0;
    else if (run && !expired)   tmr_q <= tmr_q + TMR_W'(1);
  end

  assign residue = cnt_q;
  assign expired = (tmr_q == TMR_W'(TIMEOUT - 1));
endmodule

// File: rtl/rc_code_update.sv
module rc_code_update
  import rc_tune_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 9
) (
  input  logic [CODE_W-1:0]       code_now,
  input  logic signed [CNT_W-1:0] residue,
  output logic [CODE_W-1:0]       code_next,
  output logic                    clamped
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  upd_result_t res;
  int          adj;

  always_comb begin
    adj       = halve_round(int'(residue));
    res       = clamp_add(int'(code_now), adj, MAX_CODE);
    code_next = res.code[CODE_W-1:0];
    clamped   = res.clamped;
  end
endmodule

// File: rtl/rc_tune_ctrl.sv
module rc_tune_ctrl
  import rc_tune_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int INIT_CODE = 4,
  parameter int PRESET    = 32,
  parameter int TIMEOUT   = 128,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              osc_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sat_o,
  output logic              timeout_o
);
  localparam int CNT_W = $clog2(PRESET + TIMEOUT) + 1;

  tune_state_t             state_q;
  logic [CODE_W-1:0]       code_q;
  logic                    done_q, sat_q, to_q;
  logic                    osc_hi, osc_rise, osc_fall;
  logic signed [CNT_W-1:0] residue;
  logic                    expired;
  logic [CODE_W-1:0]       code_next;
  logic                    clamped;

  // named internal events
  logic start_acc, cnt_load, cnt_dec, meas_end, meas_abort;

  rc_osc_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .osc_raw(osc_i),
    .osc_hi(osc_hi), .osc_rise(osc_rise), .osc_fall(osc_fall)
  );

  rc_phase_counter #(.PRESET(PRESET), .TIMEOUT(TIMEOUT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .dec(cnt_dec),
    .run(busy_o), .residue(residue), .expired(expired)
  );

  rc_code_update #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_upd (
    .code_now(code_q), .residue(residue),
    .code_next(code_next), .clamped(clamped)
  );

  assign start_acc  = start_i && (state_q == ST_IDLE);
  assign cnt_load   = start_acc;
  assign cnt_dec    = ((state_q == ST_ARM) && osc_rise) || ((state_q == ST_MEAS) && osc_hi);
  assign meas_end   = (state_q == ST_MEAS) && osc_fall;
  assign meas_abort = ((state_q == ST_ARM) || (state_q == ST_MEAS)) && expired && !meas_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= CODE_W'(INIT_CODE);
      done_q  <= 1'b0;
      sat_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_acc) begin
          state_q <= ST_ARM;
          sat_q   <= 1'b0;
          to_q    <= 1'b0;
        end
        ST_ARM: begin
          if (meas_abort) begin
            state_q <= ST_IDLE;
            to_q    <= 1'b1;
          end else if (osc_rise) begin
            state_q <= ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (meas_end) begin
            state_q <= ST_WRITE;
          end else if (meas_abort) begin
            state_q <= ST_IDLE;
            to_q    <= 1'b1;
          end
        end
        ST_WRITE: begin
          code_q  <= code_next;
          sat_q   <= clamped;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_o    = code_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign sat_o     = sat_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/rc_tune_chk.sv
module rc_tune_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CODE_W-1:0] code_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              sat_o,
  input logic              timeout_o
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> done_o);

  p_abort_keeps_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> ($stable(code_o) && !done_o && !busy_o));

  p_clamp_at_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_o) |-> done_o);

  p_flags_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (!sat_o && !timeout_o));
endmodule

bind rc_tune_ctrl rc_tune_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_o(code_o),
  .busy_o(busy_o), .done_o(done_o), .sat_o(sat_o), .timeout_o(timeout_o)
);

// File: tb/tb_rc_tune_ctrl.sv
module tb_rc_tune_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       osc_i = 1'b0;
  logic [2:0] code_o;
  logic       busy_o, done_o, sat_o, timeout_o;

  int checks = 0;
  int errors = 0;
  bit ended = 0;
  int model_code = 4;

  localparam int NVEC = 10;
  localparam int HVEC [NVEC] = '{32, 30, 36, 31, 33, 20, 50, 27, 64, 40};

  always #2.5 clk = ~clk;

  rc_tune_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .osc_i(osc_i),
    .code_o(code_o), .busy_o(busy_o), .done_o(done_o),
    .sat_o(sat_o), .timeout_o(timeout_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: residue 32-H, halve with ties away from zero, clamp 0..7
  task automatic predict(input int h, output int code, output int sat);
    int r, q, s;
    r = 32 - h;
    if (r > 0)      q = (r + 1) / 2;
    else if (r < 0) q = (r - 1) / 2;
    else            q = 0;
    s = model_code + q;
    sat = (s < 0 || s > 7) ? 1 : 0;
    code = (s < 0) ? 0 : (s > 7) ? 7 : s;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic high_phase(input int h, input bit poke);
    osc_i = 1'b1;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      start_i = (poke && i == 3);
    end
    start_i = 1'b0;
    osc_i = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
  endtask

  task automatic run_case(input int h, input bit poke, input string req);
    int ec, es;
    bit seen;
    predict(h, ec, es);
    pulse_start();
    check({req, " busy after start"}, int'(busy_o), 1);
    repeat (2) @(negedge clk);
    high_phase(h, poke);
    wait_done(req, seen);
    check({req, " done seen"}, int'(seen), 1);
    check({req, " code"}, int'(code_o), ec);
    check({req, " sat"}, int'(sat_o), es);
    @(negedge clk);
    check("R7 done one cycle", int'(done_o), 0);
    check("R7 code held", int'(code_o), ec);
    model_code = ec;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ec, es;
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 code", int'(code_o), 4);
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 sat", int'(sat_o), 0);
    check("R1 timeout", int'(timeout_o), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      run_case(HVEC[v], 1'b0, "R4 R5 R6 vector");
    end

    // R2: start while busy ignored
    model_code = code_o;
    run_case(30, 1'b1, "R2 start during measurement");

    // R3: phase in progress at start is not measured
    predict(32, ec, es);
    osc_i = 1'b1;
    repeat (4) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    osc_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 still busy after partial phase", int'(busy_o), 1);
    high_phase(32, 1'b0);
    wait_done("R3", seen);
    check("R3 done", int'(seen), 1);
    check("R3 code from full phase", int'(code_o), ec);
    repeat (3) @(negedge clk);

    // R5: one clock over/under nominal
    model_code = code_o;
    run_case(33, 1'b0, "R5 one long");
    run_case(31, 1'b0, "R5 one short");

    // R6 then R8 and R9: saturate, then timeout clears sat
    run_case(10, 1'b0, "R6 clamp high");
    check("R6 sat set", int'(sat_o), 1);
    ec = code_o;
    pulse_start();
    check("R9 sat cleared by start", int'(sat_o), 0);
    seen = 0;
    for (int i = 0; i < 140; i++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
    check("R8 timeout flag", int'(timeout_o), 1);
    check("R8 busy released", int'(busy_o), 0);
    check("R8 no done", int'(seen), 0);
    check("R8 code unchanged", int'(code_o), ec);
    pulse_start();
    check("R9 timeout cleared by start", int'(timeout_o), 0);
    repeat (2) @(negedge clk);
    model_code = code_o;
    predict(32, ec, es);
    high_phase(32, 1'b0);
    wait_done("R9", seen);
    check("R9 measurement after timeout", int'(code_o), ec);

    ended = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule